// File: doc/BRIEF.md
# SPI Master Byte Engine with Watermark FIFOs

This block is an SPI master that shifts bytes out of a transmit FIFO and collects returned bytes into a receive FIFO, each FIFO 64 entries deep. One burst can be far longer than a FIFO. The block raises level-sensitive watermark interrupts: one when the receive side is nearly full and one when the transmit side is nearly empty. Software uses them to drain and refill the FIFOs while the burst runs. A third interrupt source marks the end of the burst.

Software programs a burst length and sets a self-clearing start bit. The engine asserts chip select for the whole burst. It works in SPI mode 0, most significant bit first. When the transmit FIFO has run dry, the serial clock stops. It also stops when an optional pause control is set and the receive FIFO is full, so no received byte is lost. Registers are reached through a simple word-indexed write/read port. Bytes enter and leave the FIFOs through dedicated push and pop ports.

Top module: `spi_wm_master`

## Requirements
- R1: Each FIFO holds 64 bytes. A push to a full transmit FIFO is ignored, and so is a pop from an empty receive FIFO. The FIFO status register (address 4) gives the receive count in bits [6:0] and the transmit count in bits [22:16].
- R2: Register addresses on `reg_addr`: 0 control, 1 interrupt enable, 2 interrupt status, 3 burst length, 4 FIFO status. In the control register, bit 0 is start, which self-clears and reads as 0, and bit 18 is pause. The burst length register keeps 24 bits, and its upper bits read 0.
- R3: The link runs in SPI mode 0, MSB first. SCLK idles low. MOSI is stable before each rising edge and MISO is sampled on it. Each SCLK half period lasts CLK_HALF clock cycles.
- R4: Chip select (active low) falls when a burst of N>0 bytes starts and rises after the last byte. A burst gives exactly 8N rising SCLK edges.
- R5: A burst longer than the FIFO depth carries every byte correctly while software refills and drains the FIFOs during it.
- R6: While bytes of the burst remain and the transmit FIFO is empty, SCLK stays low and no bits are shifted until a byte is pushed.
- R7: With pause set, no new byte starts while the receive FIFO holds 64 bytes, and the burst resumes after a pop with nothing lost. Without pause, bytes that arrive while the receive FIFO is full are dropped.
- R8: Status bit 4 (receive watermark) sets whenever the receive count is 48 or more, and it sets again after being cleared while that still holds.
- R9: Status bit 12 (transmit watermark) sets whenever the transmit count is below 16, and it sets again after being cleared while that still holds.
- R10: Status bit 16 (complete) sets once the programmed byte count has been shifted. Received bytes stay readable afterwards.
- R11: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R12: `irq` is high exactly when some status bit and the matching enable bit (same positions 4, 12, 16) are both 1.
- R13: A start while a burst is running is ignored. A start with burst length 0 sets complete without asserting chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tx_push | input | 1 | Push `tx_byte` into the transmit FIFO |
| tx_byte | input | 8 | Byte to transmit |
| rx_pop | input | 1 | Pop the receive FIFO head |
| rx_byte | output | 8 | Receive FIFO head |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Master data in |
| spi_cs_n | output | 1 | Chip select, active low |
| irq | output | 1 | Interrupt request |

## Verification
Register reads are combinational, so the bench drives on the falling edge and samples one time unit later in the same cycle. FIFO counts and status bits are registered, so the bench reads them one full cycle after the push, pop or clear that should move them. SPI results have no fixed latency because of the stalls. The bench therefore polls the complete bit, then compares the bytes captured by its slave model, the popped bytes and the number of rising SCLK edges against values computed from the burst length. For stall cases it waits well past the time a full FIFO's worth of bytes needs, then checks that the edge count has frozen at its predicted value.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;

    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_IEN   = 3'd1,
        RA_ISTAT = 3'd2,
        RA_BLEN  = 3'd3,
        RA_FSTAT = 3'd4
    } reg_addr_e;

    localparam int BIT_START  = 0;
    localparam int BIT_RXHIGH = 4;
    localparam int BIT_TXLOW  = 12;
    localparam int BIT_DONE   = 16;
    localparam int BIT_PAUSE  = 18;

    localparam int FSTAT_TX_LSB = 16;

    typedef struct packed {
        logic done;
        logic tx_low;
        logic rx_high;
    } irq_vec_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOAD,
        ENG_SHIFT,
        ENG_FINISH
    } eng_state_e;

    function automatic logic [REG_W-1:0] irq_to_word(irq_vec_t v);
        logic [REG_W-1:0] w;
        w = '0;
        w[BIT_RXHIGH] = v.rx_high;
        w[BIT_TXLOW]  = v.tx_low;
        w[BIT_DONE]   = v.done;
        return w;
    endfunction

    function automatic irq_vec_t word_to_irq(logic [REG_W-1:0] w);
        irq_vec_t v;
        v.rx_high = w[BIT_RXHIGH];
        v.tx_low  = w[BIT_TXLOW];
        v.done    = w[BIT_DONE];
        return v;
    endfunction

endpackage

// File: rtl/spi_wm_fifo.sv
module spi_wm_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cnt_q;
    logic              do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    assert_full_push_R1: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (cnt_q == $past(cnt_q)));

    assert_empty_pop_R1: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> (cnt_q == '0));

endmodule

// File: rtl/spi_wm_regs.sv
module spi_wm_regs
    import spi_wm_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LEN_W = 24,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int RX_MARK = DEPTH - DEPTH / 4,
    localparam int TX_MARK = DEPTH / 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic [CW-1:0]    rx_cnt,
    input  logic [CW-1:0]    tx_cnt,
    input  logic             xfer_done,
    output logic             start,
    output logic             pause_en,
    output logic [LEN_W-1:0] burst_len,
    output logic             irq
);

    irq_vec_t         ien_q, stat_q, stat_set, stat_clr, stat_next;
    logic             pause_q;
    logic [LEN_W-1:0] blen_q;
    logic             unused_wdata;

    assign unused_wdata = ^wdata;

    assign stat_set.rx_high = (rx_cnt >= CW'(RX_MARK));
    assign stat_set.tx_low  = (tx_cnt <  CW'(TX_MARK));
    assign stat_set.done    = xfer_done;

    assign stat_clr  = (we && addr == RA_ISTAT) ? word_to_irq(wdata) : '0;
    assign stat_next = irq_vec_t'((stat_q & ~stat_clr) | stat_set);

    assign start     = we && (addr == RA_CTRL) && wdata[BIT_START];
    assign pause_en  = pause_q;
    assign burst_len = blen_q;
    assign irq       = |(stat_q & ien_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q   <= '0;
            stat_q  <= '0;
            pause_q <= 1'b0;
            blen_q  <= '0;
        end else begin
            stat_q <= stat_next;
            if (we) begin
                case (addr)
                    RA_CTRL: pause_q <= wdata[BIT_PAUSE];
                    RA_IEN:  ien_q   <= word_to_irq(wdata);
                    RA_BLEN: blen_q  <= wdata[LEN_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CTRL:  rdata[BIT_PAUSE] = pause_q;
            RA_IEN:   rdata = irq_to_word(ien_q);
            RA_ISTAT: rdata = irq_to_word(stat_q);
            RA_BLEN:  rdata[LEN_W-1:0] = blen_q;
            RA_FSTAT: begin
                rdata[CW-1:0] = rx_cnt;
                rdata[FSTAT_TX_LSB +: CW] = tx_cnt;
            end
            default:  rdata = '0;
        endcase
    end

    assert_rx_mark_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt >= CW'(RX_MARK)) |=> stat_q.rx_high);

    assert_tx_mark_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt < CW'(TX_MARK)) |=> stat_q.tx_low);

    assert_done_set_R10: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> stat_q.done);

    assert_w1c_R11: assert property (@(posedge clk) disable iff (rst)
        (we && addr == RA_ISTAT && wdata[BIT_DONE] && !xfer_done) |=> !stat_q.done);

endmodule

// File: rtl/spi_wm_engine.sv
module spi_wm_engine
    import spi_wm_pkg::*;
#(
    parameter int LEN_W    = 24,
    parameter int CLK_HALF = 2,
    localparam int DW = $clog2(CLK_HALF + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] burst_len,
    input  logic             pause_en,
    input  logic             tx_empty,
    input  logic [7:0]       tx_head,
    input  logic             rx_full,
    input  logic             spi_miso,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    output logic             xfer_done,
    output logic             spi_sclk,
    output logic             spi_mosi,
    output logic             spi_cs_n
);

    localparam logic [DW-1:0] DIV_END = DW'(CLK_HALF - 1);

    eng_state_e       state_q;
    logic [LEN_W-1:0] remain_q;
    logic [7:0]       tx_sh_q, rx_sh_q;
    logic [2:0]       bit_q;
    logic [DW-1:0]    div_q;
    logic             sclk_q, cs_n_q;
    logic             edge_now, rise, fall, byte_end, can_go;

    assign edge_now = (state_q == ENG_SHIFT) && (div_q == DIV_END);
    assign rise     = edge_now && !sclk_q;
    assign fall     = edge_now && sclk_q;
    assign byte_end = fall && (bit_q == 3'd7);
    assign can_go   = (state_q == ENG_LOAD) && (remain_q != '0) && !tx_empty
                      && !(pause_en && rx_full);

    assign tx_pop    = can_go;
    assign rx_push   = byte_end;
    assign rx_data   = rx_sh_q;
    assign xfer_done = (state_q == ENG_FINISH);
    assign spi_sclk  = sclk_q;
    assign spi_mosi  = tx_sh_q[7];
    assign spi_cs_n  = cs_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ENG_IDLE;
            remain_q <= '0;
            tx_sh_q  <= '0;
            rx_sh_q  <= '0;
            bit_q    <= '0;
            div_q    <= '0;
            sclk_q   <= 1'b0;
            cs_n_q   <= 1'b1;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        remain_q <= burst_len;
                        if (burst_len == '0) begin
                            state_q <= ENG_FINISH;
                        end else begin
                            state_q <= ENG_LOAD;
                            cs_n_q  <= 1'b0;
                        end
                    end
                end
                ENG_LOAD: begin
                    if (remain_q == '0) begin
                        state_q <= ENG_FINISH;
                        cs_n_q  <= 1'b1;
                    end else if (can_go) begin
                        tx_sh_q <= tx_head;
                        bit_q   <= '0;
                        div_q   <= '0;
                        state_q <= ENG_SHIFT;
                    end
                end
                ENG_SHIFT: begin
                    div_q <= edge_now ? '0 : div_q + 1'b1;
                    if (rise) begin
                        sclk_q  <= 1'b1;
                        rx_sh_q <= {rx_sh_q[6:0], spi_miso};
                    end
                    if (fall) begin
                        sclk_q <= 1'b0;
                        if (byte_end) begin
                            remain_q <= remain_q - 1'b1;
                            state_q  <= ENG_LOAD;
                        end else begin
                            tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                            bit_q   <= bit_q + 1'b1;
                        end
                    end
                end
                ENG_FINISH: begin
                    cs_n_q  <= 1'b1;
                    state_q <= ENG_IDLE;
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assert_idle_clk_low_R3: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    assert_cs_during_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ENG_SHIFT) |-> !spi_cs_n);

    assert_byte_count_R4: assert property (@(posedge clk) disable iff (rst)
        byte_end |=> (remain_q == $past(remain_q) - 1'b1));

    assert_tx_stall_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ENG_LOAD && tx_empty && remain_q != '0) |=> (!spi_sclk && $stable(remain_q)));

    assert_pause_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ENG_LOAD && pause_en && rx_full) |=> (!spi_sclk && $stable(remain_q)));

endmodule

// File: rtl/spi_wm_master.sv
module spi_wm_master
    import spi_wm_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int LEN_W      = 24,
    parameter int CLK_HALF   = 2,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_push,
    input  logic [7:0]  tx_byte,
    input  logic        rx_pop,
    output logic [7:0]  rx_byte,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n,
    output logic        irq
);

    logic             start, pause_en, xfer_done;
    logic [LEN_W-1:0] burst_len;
    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             eng_tx_pop, eng_rx_push;
    logic [7:0]       tx_head, eng_rx_data;
    logic             unused_flags;

    assign unused_flags = tx_full ^ rx_empty;

    spi_wm_regs #(.DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .rx_cnt    (rx_cnt),
        .tx_cnt    (tx_cnt),
        .xfer_done (xfer_done),
        .start     (start),
        .pause_en  (pause_en),
        .burst_len (burst_len),
        .irq       (irq)
    );

    spi_wm_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(8)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .din   (tx_byte),
        .pop   (eng_tx_pop),
        .dout  (tx_head),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_wm_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(8)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (eng_rx_push),
        .din   (eng_rx_data),
        .pop   (rx_pop),
        .dout  (rx_byte),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_wm_engine #(.LEN_W(LEN_W), .CLK_HALF(CLK_HALF)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .burst_len (burst_len),
        .pause_en  (pause_en),
        .tx_empty  (tx_empty),
        .tx_head   (tx_head),
        .rx_full   (rx_full),
        .spi_miso  (spi_miso),
        .tx_pop    (eng_tx_pop),
        .rx_push   (eng_rx_push),
        .rx_data   (eng_rx_data),
        .xfer_done (xfer_done),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_cs_n  (spi_cs_n)
    );

endmodule

// File: tb/spi_wm_master_test.sv
module spi_wm_master_test;
    import spi_wm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int MAXB       = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_byte = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_byte;
    logic        spi_sclk, spi_mosi, spi_cs_n, irq;
    logic        spi_miso = 1'b0;

    spi_wm_master #(.FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_push(tx_push),
        .tx_byte(tx_byte), .rx_pop(rx_pop), .rx_byte(rx_byte),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sbyte(input int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    // slave model: mode 0, MSB first
    logic [7:0] slv_sh = '0;
    logic [7:0] slv_cap [MAXB];
    int slv_bit = 0, slv_byte = 0, rise_cnt = 0, cs_falls = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0;

    always @(spi_cs_n, spi_sclk) begin
        logic [7:0] nb;
        if (prev_cs && !spi_cs_n) begin
            slv_bit = 0; slv_byte = 0; cs_falls++;
            nb = sbyte(0);
            spi_miso = nb[7];
        end else if (spi_sclk && !prev_sclk) begin
            slv_sh = {slv_sh[6:0], spi_mosi};
            slv_bit++;
            rise_cnt++;
        end else if (!spi_sclk && prev_sclk && !spi_cs_n) begin
            if (slv_bit == 8) begin
                if (slv_byte < MAXB) slv_cap[slv_byte] = slv_sh;
                slv_byte++;
                slv_bit = 0;
            end
            nb = sbyte(slv_byte);
            spi_miso = nb[7 - slv_bit];
        end
        prev_cs = spi_cs_n;
        prev_sclk = spi_sclk;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    logic [7:0] txq   [MAXB];
    logic [7:0] rxgot [MAXB];
    int n_cur = 0, pushed = 0, popped = 0, tx_allow = 0, base_rise = 0;

    // one cycle: decide push/pop at the falling edge, pulse for one rising edge
    task automatic step(input bit do_pop);
        logic [31:0] fs;
        @(negedge clk);
        rd(RA_FSTAT, fs);
        if (fs[22:16] < 7'(DEPTH) && pushed < n_cur && pushed < tx_allow) begin
            tx_push = 1'b1; tx_byte = txq[pushed]; pushed++;
        end
        if (do_pop && fs[6:0] != 0 && popped < MAXB && ($urandom % 4) != 0) begin
            rx_pop = 1'b1; rxgot[popped] = rx_byte; popped++;
        end
        @(posedge clk);
        #1;
        tx_push = 1'b0; rx_pop = 1'b0;
    endtask

    task automatic prepare(input int n, input int allow);
        n_cur = n; pushed = 0; popped = 0; tx_allow = allow;
        for (int k = 0; k < MAXB; k++) txq[k] = 8'($urandom);
        base_rise = rise_cnt;
    endtask

    task automatic prepush();
        int lim;
        lim = (n_cur < DEPTH) ? n_cur : DEPTH;
        if (tx_allow < lim) lim = tx_allow;
        while (pushed < lim) step(1'b0);
    endtask

    task automatic launch(input int n, input bit pause);
        wr(RA_BLEN, 32'(n));
        wr(RA_CTRL, (32'(pause) << BIT_PAUSE) | 32'h1);
    endtask

    task automatic wait_tc(input bit do_pop, input string req);
        logic [31:0] st;
        bit got = 0;
        for (int c = 0; c < 20000; c++) begin
            step(do_pop);
            rd(RA_ISTAT, st);
            if (st[BIT_DONE] && (!do_pop || popped >= n_cur)) begin
                got = 1;
                break;
            end
        end
        chk(got, {req, " burst completes"}, got, 1);
    endtask

    task automatic pop_raw(output logic [7:0] b);
        @(negedge clk);
        b = rx_byte; rx_pop = 1'b1;
        @(posedge clk);
        #1 rx_pop = 1'b0;
    endtask

    task automatic push_raw(input logic [7:0] b);
        @(negedge clk);
        tx_byte = b; tx_push = 1'b1;
        @(posedge clk);
        #1 tx_push = 1'b0;
    endtask

    task automatic verify(input int n, input int nrx, input string req);
        int mm_tx = 0, mm_rx = 0;
        for (int k = 0; k < n; k++) if (slv_cap[k] !== txq[k]) mm_tx++;
        for (int k = 0; k < nrx; k++) if (rxgot[k] !== sbyte(k)) mm_rx++;
        chk(mm_tx == 0, {req, " R3 MOSI bytes MSB first"}, mm_tx, 0);
        chk(mm_rx == 0, {req, " R3 MISO bytes MSB first"}, mm_rx, 0);
        chk(rise_cnt - base_rise == 8 * n, {req, " R4 rising edge count"}, rise_cnt - base_rise, 8 * n);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(negedge clk);
        begin
            logic [31:0] v;
            logic [7:0] b;
            int mm;

            // reset state
            chk(spi_cs_n == 1'b1, "R4 cs_n idle after reset", spi_cs_n, 1);
            chk(spi_sclk == 1'b0, "R3 sclk idle after reset", spi_sclk, 0);
            chk(irq == 1'b0, "R12 irq low after reset", irq, 0);
            rd(RA_FSTAT, v); chk(v == 0, "R1 FIFO status after reset", v, 0);
            rd(RA_CTRL, v);  chk(v == 0, "R2 control after reset", v, 0);
            rd(RA_ISTAT, v); chk(v == 32'h1000, "R9 tx watermark with empty FIFO", v, 32'h1000);

            // register fields
            wr(RA_BLEN, 32'hFFFF_FFFF);
            rd(RA_BLEN, v); chk(v == 32'h00FF_FFFF, "R2 burst length width", v, 32'h00FF_FFFF);
            wr(RA_CTRL, 32'h0004_0000);
            rd(RA_CTRL, v); chk(v == 32'h0004_0000, "R2 pause readback", v, 32'h0004_0000);
            wr(RA_CTRL, 32'h0);

            // pop from empty, push to full
            pop_raw(b);
            @(negedge clk); rd(RA_FSTAT, v);
            chk(v[6:0] == 0, "R1 pop from empty ignored", v[6:0], 0);
            prepare(64, 64);
            prepush();
            for (int k = 0; k < 6; k++) push_raw(~txq[k]);
            @(negedge clk); rd(RA_FSTAT, v);
            chk(v[22:16] == 64, "R1 push to full ignored", v[22:16], 64);
            launch(64, 1'b0);
            wait_tc(1'b1, "R1");
            verify(64, popped, "R1");
            @(negedge clk); rd(RA_FSTAT, v);
            chk(v[22:16] == 0, "R1 extra pushes did not remain", v[22:16], 0);
            wr(RA_ISTAT, 32'h0001_1010);

            // short burst, data left in rx FIFO after complete
            prepare(5, 5);
            prepush();
            launch(5, 1'b0);
            wait_tc(1'b0, "R10");
            chk(spi_cs_n == 1'b1, "R4 cs_n released after burst", spi_cs_n, 1);
            @(negedge clk); rd(RA_FSTAT, v);
            chk(v[6:0] == 5, "R10 received bytes kept", v[6:0], 5);
            for (int k = 0; k < 5; k++) begin pop_raw(b); rxgot[k] = b; end
            verify(5, 5, "R10");

            // write-one-to-clear, level re-set of tx watermark
            @(negedge clk); rd(RA_ISTAT, v);
            chk(v[BIT_DONE] == 1'b1, "R10 complete bit set", v[BIT_DONE], 1);
            wr(RA_ISTAT, 32'h0000_0000);
            rd(RA_ISTAT, v); chk(v[BIT_DONE] == 1'b1, "R11 writing zero keeps bit", v[BIT_DONE], 1);
            wr(RA_ISTAT, 32'h0001_1000);
            rd(RA_ISTAT, v);
            chk(v[BIT_DONE] == 1'b0, "R11 complete bit cleared", v[BIT_DONE], 0);
            chk(v[BIT_TXLOW] == 1'b1, "R9 tx watermark sets again", v[BIT_TXLOW], 1);

            // interrupt output
            wr(RA_IEN, 32'h0001_0000);
            chk(irq == 1'b0, "R12 irq low with no enabled source", irq, 0);
            prepare(2, 2);
            prepush();
            launch(2, 1'b0);
            wait_tc(1'b1, "R12");
            @(negedge clk);
            chk(irq == 1'b1, "R12 irq on complete", irq, 1);
            wr(RA_ISTAT, 32'h0001_0000);
            chk(irq == 1'b0, "R12 irq drops after clear", irq, 0);
            wr(RA_IEN, 32'h0000_1000);
            chk(irq == 1'b1, "R12 irq from tx watermark", irq, 1);
            wr(RA_IEN, 32'h0);
            chk(irq == 1'b0, "R12 irq masked", irq, 0);

            // long burst with pause and random draining
            wr(RA_ISTAT, 32'h0001_1010);
            prepare(200, 200);
            prepush();
            launch(200, 1'b1);
            wait_tc(1'b1, "R5");
            verify(200, popped, "R5");
            chk(popped == 200, "R5 all bytes popped", popped, 200);

            // pause holds while rx full
            wr(RA_ISTAT, 32'h0001_1010);
            prepare(70, 70);
            prepush();
            launch(70, 1'b1);
            for (int c = 0; c < 3000; c++) step(1'b0);
            chk(rise_cnt - base_rise == 512, "R7 clock frozen when rx full", rise_cnt - base_rise, 512);
            @(negedge clk); rd(RA_FSTAT, v);
            chk(v[6:0] == 64, "R7 rx FIFO full while paused", v[6:0], 64);
            chk(spi_cs_n == 1'b0, "R4 cs_n held during pause", spi_cs_n, 0);
            rd(RA_ISTAT, v); chk(v[BIT_RXHIGH] == 1'b1, "R8 rx watermark set", v[BIT_RXHIGH], 1);
            wr(RA_ISTAT, 32'h0000_0010);
            rd(RA_ISTAT, v); chk(v[BIT_RXHIGH] == 1'b1, "R8 rx watermark sets again", v[BIT_RXHIGH], 1);
            wait_tc(1'b1, "R7");
            verify(70, popped, "R7 paused burst");
            @(negedge clk);
            wr(RA_ISTAT, 32'h0001_1010);
            rd(RA_ISTAT, v); chk(v[BIT_RXHIGH] == 1'b0, "R8 rx watermark clears when drained", v[BIT_RXHIGH], 0);

            // no pause: overflow bytes dropped
            prepare(66, 66);
            prepush();
            launch(66, 1'b0);
            wait_tc(1'b0, "R7");
            @(negedge clk); rd(RA_FSTAT, v);
            chk(v[6:0] == 64, "R7 rx FIFO saturates without pause", v[6:0], 64);
            for (int k = 0; k < 64; k++) begin pop_raw(b); rxgot[k] = b; end
            verify(66, 64, "R7 unpaused burst");
            @(negedge clk); rd(RA_FSTAT, v);
            chk(v[6:0] == 0, "R7 dropped bytes never stored", v[6:0], 0);
            wr(RA_ISTAT, 32'h0001_1010);

            // tx empty stall
            prepare(4, 2);
            prepush();
            launch(4, 1'b0);
            for (int c = 0; c < 300; c++) step(1'b1);
            chk(rise_cnt - base_rise == 16, "R6 clock stops when tx empty", rise_cnt - base_rise, 16);
            chk(spi_cs_n == 1'b0, "R6 cs_n held during stall", spi_cs_n, 0);
            chk(spi_sclk == 1'b0, "R6 sclk low during stall", spi_sclk, 0);
            rd(RA_ISTAT, v); chk(v[BIT_DONE] == 1'b0, "R6 no complete during stall", v[BIT_DONE], 1'b0);
            tx_allow = 4;
            wait_tc(1'b1, "R6");
            verify(4, popped, "R6");
            wr(RA_ISTAT, 32'h0001_1010);

            // zero-length burst
            mm = cs_falls;
            launch(0, 1'b0);
            repeat (3) @(negedge clk);
            rd(RA_ISTAT, v); chk(v[BIT_DONE] == 1'b1, "R13 zero length completes", v[BIT_DONE], 1);
            chk(cs_falls == mm, "R13 zero length keeps cs_n high", cs_falls - mm, 0);
            wr(RA_ISTAT, 32'h0001_1010);

            // start while busy
            prepare(3, 3);
            prepush();
            launch(3, 1'b0);
            for (int c = 0; c < 20; c++) step(1'b1);
            launch(9, 1'b0);
            wait_tc(1'b1, "R13");
            for (int c = 0; c < 400; c++) step(1'b1);
            verify(3, popped, "R13 restart ignored");
            rd(RA_BLEN, v); chk(v == 9, "R13 length register still writable", v, 9);
        end
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule